// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central scheduler for five functional units: one integer/load unit, two multipliers, one adder and one divider. Instructions arrive in program order on an issue port. Each instruction carries a unit kind, an operation code, a destination register and two source registers. The block assigns each accepted instruction to a free unit. It then moves the instruction through four steps: it waits for its operands, reads them, executes, and writes its result. For each step the block drives a grant, and each functional unit reports the end of its work on a done input.

All hazard decisions are made on register numbers alone, and no result is ever forwarded. The block keeps a status table with one entry per unit and a pending-writer table with one entry per register. It uses them to stall issue on structural and output (WAW) hazards, to hold operand reads until the producers have written back (RAW), and to hold a write-back while an earlier reader still needs the old register value (WAR). Interrupts are imprecise. The register file, the units themselves, memory and fetch all sit outside the block.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: After reset all units are free. No `rd_grant`, `exec_start` or `wb_grant` bit is set, and `iss_grant` stays low while `iss_valid` is low.
- R2: Unit kinds are encoded as 0 integer (unit 0), 1 multiply (units 1 and 2), 2 add (unit 3) and 3 divide (unit 4). `iss_grant` is combinational. It rises only when a unit of the requested kind is free, and `iss_unit` then names the lowest-numbered free unit of that kind. The instruction is held when no unit of that kind is free.
- R3: Issue is held while any issued but unfinished instruction has the same destination register as the instruction at the head.
- R4: Bit i of `rd_grant` is set in a cycle where unit i is waiting for operands and both of its sources are ready. The earliest such cycle is the one after issue. Bit i of `exec_start` follows for exactly the next cycle.
- R5: A source that has a pending producer when its instruction issues becomes ready only after that producer's write-back. The consumer's `rd_grant` comes no earlier than the cycle after the producer's `wb_grant`.
- R6: `fu_done[i]` is taken into account only once unit i has passed its `exec_start` cycle. At other times it is ignored. A done that is taken makes unit i eligible for `wb_grant` in the next cycle.
- R7: A write-back is held while another unit is still waiting to read its operands, and one of that unit's ready, unread sources is the writer's destination register.
- R8: At most one `wb_grant` bit is set per cycle, and the lowest eligible unit index wins. `wb_reg` carries the destination register of the granted unit.
- R9: After its write-back cycle a unit is free again, and its destination register has no pending writer.
- R10: An instruction that issues in the same cycle as the write-back of one of its producers treats that source as ready. It can receive `rd_grant` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Head instruction present |
| iss_kind | input | 2 | Unit kind requested (0 int, 1 mul, 2 add, 3 div) |
| iss_op | input | 4 | Operation code passed to the unit |
| iss_dst | input | 3 | Destination register |
| iss_src1 | input | 3 | First source register |
| iss_src2 | input | 3 | Second source register |
| fu_done | input | 5 | Per-unit completion report |
| iss_grant | output | 1 | Head instruction accepted this cycle |
| iss_unit | output | 3 | Index of the unit that takes the instruction |
| rd_grant | output | 5 | Per-unit operand read permission |
| exec_start | output | 5 | Per-unit start of execution |
| exec_op | output | 5x4 | Operation code held by each unit |
| wb_grant | output | 5 | One-hot write-back permission |
| wb_reg | output | 3 | Register written by the granted unit |

## Verification
All grants are combinational on the registered state. An issue is therefore seen in the cycle the request is driven, the operand read one cycle after issue, the execute start one cycle after the read, and the write-back one cycle after an accepted done. The bench drives inputs just after the falling edge and samples one time unit later. It counts the expected cycle of every grant from these latencies. Each scenario checks both the cycle in which a grant must appear and the cycles just before it, in which the grant must still be held. That covers the WAR and RAW cases, where the grant is held for the full length of the hazard.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int NUM_FU   = 5;
    localparam int NUM_REGS = 8;
    localparam int REG_W    = $clog2(NUM_REGS);
    localparam int TAG_W    = 3;
    localparam int UNIT_W   = $clog2(NUM_FU);
    localparam int OP_W     = 4;
    localparam int KIND_W   = 2;

    typedef enum logic [1:0] {
        ST_OPS   = 2'd0,
        ST_START = 2'd1,
        ST_EXEC  = 2'd2,
        ST_WRITE = 2'd3
    } stage_e;

    typedef struct packed {
        logic               busy;
        stage_e             stage;
        logic [OP_W-1:0]    op;
        logic [REG_W-1:0]   fi;
        logic [REG_W-1:0]   fj;
        logic [REG_W-1:0]   fk;
        logic [TAG_W-1:0]   qj;
        logic [TAG_W-1:0]   qk;
        logic               rj;
        logic               rk;
    } fu_entry_t;

    // Kind served by each unit index: 0 int, 1-2 mul, 3 add, 4 div.
    function automatic logic [KIND_W-1:0] unit_kind(input int idx);
        case (idx)
            0:       return 2'd0;
            1, 2:    return 2'd1;
            3:       return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // Tag 0 means no pending producer; unit i is tag i+1.
    function automatic logic [TAG_W-1:0] unit_tag(input int idx);
        return TAG_W'(idx + 1);
    endfunction

endpackage

// File: rtl/sb_issue_sel.sv
module sb_issue_sel
    import sb_pkg::*;
#(
    parameter int N_UNITS = NUM_FU
) (
    input  logic [N_UNITS-1:0] busy,
    input  logic [KIND_W-1:0]  req_kind,
    output logic               found,
    output logic [UNIT_W-1:0]  unit_idx
);

    logic [N_UNITS-1:0] free_match;

    for (genvar g = 0; g < N_UNITS; g++) begin : g_match
        assign free_match[g] = !busy[g] && (unit_kind(g) == req_kind);
    end

    always_comb begin
        found    = 1'b0;
        unit_idx = '0;
        for (int i = N_UNITS - 1; i >= 0; i--) begin
            if (free_match[i]) begin
                found    = 1'b1;
                unit_idx = UNIT_W'(i);
            end
        end
    end

endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb
    import sb_pkg::*;
#(
    parameter int N_UNITS = NUM_FU
) (
    input  fu_entry_t [N_UNITS-1:0] tbl,
    output logic [N_UNITS-1:0]      grant,
    output logic                    any,
    output logic [UNIT_W-1:0]       idx
);

    logic [N_UNITS-1:0] cand;

    for (genvar g = 0; g < N_UNITS; g++) begin : g_cand
        logic war_block;
        always_comb begin
            war_block = 1'b0;
            for (int j = 0; j < N_UNITS; j++) begin
                if (j != g && tbl[j].busy && tbl[j].stage == ST_OPS) begin
                    if ((tbl[j].rj && tbl[j].fj == tbl[g].fi) ||
                        (tbl[j].rk && tbl[j].fk == tbl[g].fi)) begin
                        war_block = 1'b1;
                    end
                end
            end
        end
        assign cand[g] = tbl[g].busy && (tbl[g].stage == ST_WRITE) && !war_block;
    end

    always_comb begin
        grant = '0;
        any   = 1'b0;
        idx   = '0;
        for (int i = N_UNITS - 1; i >= 0; i--) begin
            if (cand[i]) begin
                any = 1'b1;
                idx = UNIT_W'(i);
            end
        end
        if (any) begin
            grant[idx] = 1'b1;
        end
    end

endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl
    import sb_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           iss_valid,
    input  logic [KIND_W-1:0]              iss_kind,
    input  logic [OP_W-1:0]                iss_op,
    input  logic [REG_W-1:0]               iss_dst,
    input  logic [REG_W-1:0]               iss_src1,
    input  logic [REG_W-1:0]               iss_src2,
    input  logic [NUM_FU-1:0]              fu_done,
    output logic                           iss_grant,
    output logic [UNIT_W-1:0]              iss_unit,
    output logic [NUM_FU-1:0]              rd_grant,
    output logic [NUM_FU-1:0]              exec_start,
    output logic [NUM_FU-1:0][OP_W-1:0]    exec_op,
    output logic [NUM_FU-1:0]              wb_grant,
    output logic [REG_W-1:0]               wb_reg
);

    typedef struct packed {
        fu_entry_t [NUM_FU-1:0]               fu;
        logic      [NUM_REGS-1:0][TAG_W-1:0]  rstat;
    } sb_state_t;

    sb_state_t cur_q, nxt_d;

    logic [NUM_FU-1:0] busy_vec;
    logic              sel_found;
    logic [UNIT_W-1:0] sel_idx;
    logic              wb_any;
    logic [UNIT_W-1:0] wb_idx;
    logic [TAG_W-1:0]  wb_tag;

    for (genvar g = 0; g < NUM_FU; g++) begin : g_out
        assign busy_vec[g]   = cur_q.fu[g].busy;
        assign rd_grant[g]   = cur_q.fu[g].busy && cur_q.fu[g].stage == ST_OPS
                               && cur_q.fu[g].rj && cur_q.fu[g].rk;
        assign exec_start[g] = cur_q.fu[g].busy && cur_q.fu[g].stage == ST_START;
        assign exec_op[g]    = cur_q.fu[g].op;
    end

    sb_issue_sel #(.N_UNITS(NUM_FU)) u_sel (
        .busy     (busy_vec),
        .req_kind (iss_kind),
        .found    (sel_found),
        .unit_idx (sel_idx)
    );

    sb_wb_arb #(.N_UNITS(NUM_FU)) u_arb (
        .tbl   (cur_q.fu),
        .grant (wb_grant),
        .any   (wb_any),
        .idx   (wb_idx)
    );

    assign wb_tag    = unit_tag(int'(wb_idx));
    assign wb_reg    = wb_any ? cur_q.fu[wb_idx].fi : '0;
    assign iss_grant = iss_valid && sel_found && (cur_q.rstat[iss_dst] == '0);
    assign iss_unit  = sel_idx;

    always_comb begin
        logic [TAG_W-1:0] src_j;
        logic [TAG_W-1:0] src_k;
        nxt_d = cur_q;

        for (int i = 0; i < NUM_FU; i++) begin
            if (cur_q.fu[i].busy) begin
                case (cur_q.fu[i].stage)
                    ST_OPS: begin
                        if (rd_grant[i]) begin
                            nxt_d.fu[i].stage = ST_START;
                            nxt_d.fu[i].rj    = 1'b0;
                            nxt_d.fu[i].rk    = 1'b0;
                        end else if (wb_any) begin
                            if (cur_q.fu[i].qj == wb_tag) begin
                                nxt_d.fu[i].rj = 1'b1;
                                nxt_d.fu[i].qj = '0;
                            end
                            if (cur_q.fu[i].qk == wb_tag) begin
                                nxt_d.fu[i].rk = 1'b1;
                                nxt_d.fu[i].qk = '0;
                            end
                        end
                    end
                    ST_START: nxt_d.fu[i].stage = ST_EXEC;
                    ST_EXEC: begin
                        if (fu_done[i]) begin
                            nxt_d.fu[i].stage = ST_WRITE;
                        end
                    end
                    default: begin
                        if (wb_grant[i]) begin
                            nxt_d.fu[i].busy  = 1'b0;
                            nxt_d.fu[i].stage = ST_OPS;
                        end
                    end
                endcase
            end
        end

        if (wb_any) begin
            nxt_d.rstat[cur_q.fu[wb_idx].fi] = '0;
        end

        if (iss_grant) begin
            src_j = cur_q.rstat[iss_src1];
            src_k = cur_q.rstat[iss_src2];
            if (wb_any && src_j == wb_tag) src_j = '0;
            if (wb_any && src_k == wb_tag) src_k = '0;
            nxt_d.fu[sel_idx].busy  = 1'b1;
            nxt_d.fu[sel_idx].stage = ST_OPS;
            nxt_d.fu[sel_idx].op    = iss_op;
            nxt_d.fu[sel_idx].fi    = iss_dst;
            nxt_d.fu[sel_idx].fj    = iss_src1;
            nxt_d.fu[sel_idx].fk    = iss_src2;
            nxt_d.fu[sel_idx].qj    = src_j;
            nxt_d.fu[sel_idx].qk    = src_k;
            nxt_d.fu[sel_idx].rj    = (src_j == '0);
            nxt_d.fu[sel_idx].rk    = (src_k == '0);
            nxt_d.rstat[iss_dst]    = unit_tag(int'(sel_idx));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    AST_WB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_grant)); // R8

    AST_ISSUE_FREE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        iss_grant |-> !busy_vec[iss_unit]); // R2

    AST_DST_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
        iss_grant |=> cur_q.rstat[$past(iss_dst)] == TAG_W'($past(iss_unit) + 1'b1)); // R3

    for (genvar g = 0; g < NUM_FU; g++) begin : g_ast
        AST_READ_THEN_START: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[g] |=> exec_start[g]); // R4

        AST_WB_FREES_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant[g] |=> !busy_vec[g]); // R9
    end

endmodule

// File: tb/sb_hazard_ctrl_test.sv
module sb_hazard_ctrl_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_kind = '0;
    logic [3:0]  iss_op = '0;
    logic [2:0]  iss_dst = '0;
    logic [2:0]  iss_src1 = '0;
    logic [2:0]  iss_src2 = '0;
    logic [4:0]  fu_done = '0;
    logic        iss_grant;
    logic [2:0]  iss_unit;
    logic [4:0]  rd_grant;
    logic [4:0]  exec_start;
    logic [4:0][3:0] exec_op;
    logic [4:0]  wb_grant;
    logic [2:0]  wb_reg;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    sb_hazard_ctrl uut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_kind(iss_kind),
        .iss_op(iss_op), .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .fu_done(fu_done), .iss_grant(iss_grant), .iss_unit(iss_unit),
        .rd_grant(rd_grant), .exec_start(exec_start), .exec_op(exec_op),
        .wb_grant(wb_grant), .wb_reg(wb_reg)
    );

    task automatic chk(input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Move to the next cycle: inputs are driven after this, samples after #1.
    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic put(input bit v, input int k, input int d, input int a, input int b);
        iss_valid = v;
        iss_kind  = 2'(k);
        iss_op    = 4'(d + 3);
        iss_dst   = 3'(d);
        iss_src1  = 3'(a);
        iss_src2  = 3'(b);
    endtask

    task automatic drain();
        iss_valid = 1'b0;
        fu_done   = '1;
        repeat (16) @(negedge clk);
        fu_done   = '0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        cyc(); put(0, 0, 0, 0, 0); #1;
        chk(int'(iss_grant), 0, "R1 no grant idle");
        chk(int'(rd_grant | exec_start | wb_grant), 0, "R1 no grants after reset");
        put(1, 0, 1, 0, 0); #1;
        chk(int'(iss_grant), 1, "R1 free unit accepts");
        chk(int'(iss_unit), 0, "R2 int goes to unit 0");
        cyc(); put(0, 0, 0, 0, 0);
        drain();
    endtask

    task automatic t_basic();
        cyc(); put(1, 2, 1, 2, 3); #1;
        chk(int'(iss_grant), 1, "R2 add issue");
        chk(int'(iss_unit), 3, "R2 add unit");
        cyc(); put(0, 0, 0, 0, 0); fu_done = 5'b01000; #1;
        chk(int'(rd_grant), 5'b01000, "R4 read one cycle after issue");
        cyc(); fu_done = '0; #1;
        chk(int'(exec_start), 5'b01000, "R4 start after read");
        chk(int'(exec_op[3]), 4, "R4 op held by unit");
        cyc(); #1;
        chk(int'(wb_grant), 0, "R6 early done ignored");
        cyc(); fu_done = 5'b01000; #1;
        chk(int'(wb_grant), 0, "R6 no wb before done");
        cyc(); fu_done = '0; #1;
        chk(int'(wb_grant), 5'b01000, "R6 wb after done");
        chk(int'(wb_reg), 1, "R8 wb_reg");
        cyc(); put(1, 2, 1, 0, 0); #1;
        chk(int'(iss_grant), 1, "R9 unit and dst free after wb");
        chk(int'(iss_unit), 3, "R9 same unit reused");
        cyc(); put(0, 0, 0, 0, 0);
        drain();
    endtask

    task automatic t_struct();
        cyc(); put(1, 1, 1, 0, 0); #1;
        chk(int'(iss_unit), 1, "R2 first mul unit 1");
        cyc(); put(1, 1, 2, 0, 0); #1;
        chk(int'(iss_grant), 1, "R2 second mul granted");
        chk(int'(iss_unit), 2, "R2 second mul unit 2");
        cyc(); put(1, 1, 3, 0, 0); #1;
        chk(int'(iss_grant), 0, "R2 third mul held");
        cyc(); put(1, 0, 4, 0, 0); #1;
        chk(int'(iss_grant), 1, "R2 int still issues");
        cyc(); put(0, 0, 0, 0, 0);
        drain();
    endtask

    task automatic t_waw();
        cyc(); put(1, 3, 4, 1, 2); #1;
        chk(int'(iss_unit), 4, "R3 div unit");
        cyc(); put(1, 2, 4, 5, 6); #1;
        chk(int'(iss_grant), 0, "R3 waw held c1");
        cyc(); #1;
        chk(int'(iss_grant), 0, "R3 waw held c2");
        cyc(); fu_done = 5'b10000; #1;
        chk(int'(iss_grant), 0, "R3 waw held c3");
        cyc(); fu_done = '0; #1;
        chk(int'(wb_grant), 5'b10000, "R3 div writes");
        chk(int'(iss_grant), 0, "R3 held in wb cycle");
        cyc(); #1;
        chk(int'(iss_grant), 1, "R3 released after wb");
        cyc(); put(0, 0, 0, 0, 0);
        drain();
    endtask

    task automatic t_raw();
        cyc(); put(1, 0, 5, 0, 0); #1;
        chk(int'(iss_grant), 1, "R5 producer issue");
        cyc(); put(1, 2, 6, 5, 1); #1;
        chk(int'(iss_grant), 1, "R5 consumer issue");
        chk(int'(rd_grant), 5'b00001, "R5 producer reads");
        cyc(); put(0, 0, 0, 0, 0); #1;
        chk(int'(rd_grant), 0, "R5 consumer waits");
        cyc(); fu_done = 5'b00001; #1;
        chk(int'(rd_grant), 0, "R5 consumer waits during exec");
        cyc(); fu_done = '0; #1;
        chk(int'(wb_grant), 5'b00001, "R5 producer wb");
        chk(int'(wb_reg), 5, "R5 wb_reg");
        chk(int'(rd_grant), 0, "R5 no read in wb cycle");
        cyc(); #1;
        chk(int'(rd_grant), 5'b01000, "R5 read after wb");
        drain();
    endtask

    task automatic t_war();
        cyc(); put(1, 3, 0, 6, 7); #1;
        chk(int'(iss_unit), 4, "R7 div issue");
        cyc(); put(1, 2, 3, 0, 1); #1;
        chk(int'(iss_unit), 3, "R7 add issue");
        cyc(); put(1, 0, 1, 6, 6); #1;
        chk(int'(iss_unit), 0, "R7 int issue");
        cyc(); put(0, 0, 0, 0, 0); #1;
        chk(int'(rd_grant), 5'b00001, "R7 int reads");
        cyc(); cyc(); fu_done = 5'b00001; #1;
        cyc(); fu_done = '0; #1;
        chk(int'(wb_grant), 0, "R7 int wb held c6");
        cyc(); fu_done = 5'b10000; #1;
        chk(int'(wb_grant), 0, "R7 int wb held c7");
        cyc(); fu_done = '0; #1;
        chk(int'(wb_grant), 5'b10000, "R7 div writes instead");
        chk(int'(wb_reg), 0, "R7 div wb_reg");
        cyc(); #1;
        chk(int'(rd_grant), 5'b01000, "R7 add reads");
        chk(int'(wb_grant), 0, "R7 int held during read");
        cyc(); #1;
        chk(int'(wb_grant), 5'b00001, "R7 int writes after read");
        chk(int'(wb_reg), 1, "R7 int wb_reg");
        drain();
    endtask

    task automatic t_prio();
        cyc(); put(1, 1, 2, 0, 0); #1;
        chk(int'(iss_unit), 1, "R8 mul a");
        cyc(); put(1, 1, 3, 0, 0); #1;
        chk(int'(iss_unit), 2, "R8 mul b");
        cyc(); put(0, 0, 0, 0, 0);
        cyc();
        cyc(); fu_done = 5'b00110; #1;
        cyc(); fu_done = '0; #1;
        chk(int'(wb_grant), 5'b00010, "R8 lower unit first");
        chk(int'(wb_reg), 2, "R8 first wb_reg");
        cyc(); #1;
        chk(int'(wb_grant), 5'b00100, "R8 second unit next");
        chk(int'(wb_reg), 3, "R8 second wb_reg");
        drain();
    endtask

    task automatic t_same_cycle();
        cyc(); put(1, 0, 5, 0, 0); #1;
        chk(int'(iss_grant), 1, "R10 producer issue");
        cyc(); put(0, 0, 0, 0, 0);
        cyc();
        cyc(); fu_done = 5'b00001;
        cyc(); fu_done = '0; put(1, 2, 6, 5, 5); #1;
        chk(int'(wb_grant), 5'b00001, "R10 producer wb");
        chk(int'(iss_grant), 1, "R10 consumer issues in wb cycle");
        cyc(); put(0, 0, 0, 0, 0); #1;
        chk(int'(rd_grant), 5'b01000, "R10 consumer reads next cycle");
        drain();
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_struct();
        t_waw();
        t_raw();
        t_war();
        t_prio();
        t_same_cycle();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule